// File: doc/BRIEF.md
# Multi-Lane Serial Loopback Bit-Error Tester

This block checks a parallel bundle of serial wires one bit at a time. Its transmit half takes one 32-bit word per lane, loads it into a shift register, and sends it most significant bit first on each data lane. A separate lane carries a forwarded clock that pulses once for each data bit. Between words that clock lane stays low. Its receive half watches the forwarded clock. It finds word boundaries from the quiet gaps, shifts each lane into a word register on every rising edge, and compares the rebuilt word against the word it expected. Every bit that differs adds to that lane's error counter.

Each word sent (an iteration) carries either a fixed word, taken from an input, or a pseudo-random word. In the pseudo-random case each lane has its own LFSR stream. The receive half runs an identical set of reference LFSRs, so the two sides stay in step word by word with no side channel between them. In use, the transmit outputs run through the link under test and back into the receive inputs. Software-free operation is the norm: a `start` pulse sends one word, a held `start` sends words back to back, and `clear` zeroes the counters.

Top module: `lane_bert`

## Requirements
- R1: After reset every error counter and the word counter read zero, the forwarded clock and all data lanes are low, `tx_busy` is low and `pass` is low.
- R2: Each word produces exactly 32 forwarded-clock rising edges. A bit time is two clock cycles: data is set while the forwarded clock is low and held while it is high. Bits leave most significant first, so the first rising edge carries bit 31.
- R3: After the last bit of a word, the forwarded clock and all data lanes stay low for at least 2*GAP_BITS clock cycles before the next word's first rising edge.
- R4: With `rand_mode` low at the start of a word, every lane sends `const_word`.
- R5: With `rand_mode` high, lane i sends the current state of its own LFSR. The state starts at 32'h12345678 + i*32'h01010101, and next = (s >> 1) XOR (s[0] ? 32'hB4BCD35C : 0). Each lane's LFSR advances once per word sent, in either mode.
- R6: The receiver arms after two consecutive low cycles on the forwarded clock. It rebuilds a word from the next 32 rising edges; a burst of fewer than 32 edges followed by a gap is discarded without counting a word.
- R7: When a word completes, each lane's error counter grows by the number of bits that differ from the expected word (`const_word` or the lane's reference LFSR, chosen by `rand_mode`). The counter saturates at all ones.
- R8: `word_done` pulses for one cycle per rebuilt word, and `word_cnt` increments by one on that pulse.
- R9: A cycle with `clear` high zeroes all error counters and the word counter, taking priority over an update in the same cycle.
- R10: `pass` is high exactly when `word_cnt` is nonzero and every lane's error counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Send a word when idle; held high sends words continuously |
| rand_mode | input | 1 | 1 selects per-lane LFSR data, 0 selects the fixed word |
| const_word | input | 32 | Fixed word for non-random iterations |
| clear | input | 1 | Zero all counters |
| lane_tx | output | LANES | Serial data lanes toward the link |
| fwd_clk_tx | output | 1 | Forwarded bit clock toward the link |
| tx_busy | output | 1 | Transmitter is sending a word or its trailing gap |
| lane_rx | input | LANES | Serial data lanes from the link |
| fwd_clk_rx | input | 1 | Forwarded bit clock from the link |
| err_cnt | output | LANES*ERR_W | Per-lane saturating bit-error counters, lane 0 in the low bits |
| word_cnt | output | CNT_W | Count of words rebuilt |
| word_done | output | 1 | One-cycle pulse per rebuilt word |
| pass | output | 1 | Words received and no bit error on any lane |

## Verification
The bench builds the block with seven lanes, GAP_BITS of 2 and an 8-bit error counter. The narrow counter lets nine fully inverted words push a lane past 255, so the saturation limit is reached in a short run. The two-bit gap makes the gap between back-to-back words measurably longer than the one-bit-time gap the receiver needs to arm. Corruption is injected in the loopback path, both as an inverted lane and as a lane stuck at zero. A hand-driven partial burst on the receive inputs shows that framing discards incomplete words and then recovers.

// File: rtl/lane_bert_pkg.sv
package lane_bert_pkg;

  parameter int WORD_W = 32;
  parameter int BIT_W  = $clog2(WORD_W);
  parameter int PC_W   = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t LFSR_TAP   = 32'hB4BC_D35C;
  localparam word_t SEED_BASE  = 32'h1234_5678;
  localparam word_t SEED_STEP  = 32'h0101_0101;

  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_state_e;

  // Starting state for the pattern generator of one lane.
  function automatic word_t lane_seed(input int unsigned idx);
    word_t k;
    k = word_t'(idx);
    return SEED_BASE + k * SEED_STEP;
  endfunction

  // Right-shifting Galois step.
  function automatic word_t lfsr_next(input word_t s);
    return (s >> 1) ^ (s[0] ? LFSR_TAP : '0);
  endfunction

  function automatic logic [PC_W-1:0] popcount(input word_t w);
    logic [PC_W-1:0] n;
    n = '0;
    for (int i = 0; i < WORD_W; i++) n = n + PC_W'(w[i]);
    return n;
  endfunction

endpackage

// File: rtl/lane_bert_tx.sv
module lane_bert_tx
  import lane_bert_pkg::*;
#(
  parameter int LANES    = 7,
  parameter int GAP_BITS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rand_mode,
  input  logic [WORD_W-1:0] const_word,
  output logic [LANES-1:0] lane_tx,
  output logic             fwd_clk_tx,
  output logic             tx_busy
);

  localparam int GAP_CYC = 2 * GAP_BITS;
  localparam int GAP_CW  = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [GAP_CW-1:0] GAP_LAST = GAP_CW'(GAP_CYC - 1);

  tx_state_e          state;
  logic               phase;
  logic [BIT_W-1:0]   bit_idx;
  logic [GAP_CW-1:0]  gap_cnt;
  logic               fwd_q;

  // Named events used by the lane logic and the assertions.
  logic load_ev, shift_ev, last_bit_ev, shifting;
  assign shifting    = (state == TX_SHIFT);
  assign load_ev     = (state == TX_IDLE) && start;
  assign shift_ev    = shifting && phase;
  assign last_bit_ev = shift_ev && (bit_idx == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      phase   <= 1'b0;
      bit_idx <= '0;
      gap_cnt <= '0;
      fwd_q   <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (start) begin
            state   <= TX_SHIFT;
            phase   <= 1'b0;
            bit_idx <= '0;
          end
        end
        TX_SHIFT: begin
          if (!phase) begin
            phase <= 1'b1;
            fwd_q <= 1'b1;
          end else begin
            phase <= 1'b0;
            fwd_q <= 1'b0;
            if (bit_idx == LAST_BIT) begin
              state   <= TX_GAP;
              gap_cnt <= '0;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        TX_GAP: begin
          if (gap_cnt == GAP_LAST) state <= TX_IDLE;
          else                     gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    word_t sreg_q;
    word_t lfsr_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sreg_q <= '0;
        lfsr_q <= lane_seed(l);
      end else if (load_ev) begin
        sreg_q <= rand_mode ? lfsr_q : const_word;
        lfsr_q <= lfsr_next(lfsr_q);
      end else if (shift_ev) begin
        sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      end
    end

    assign lane_tx[l] = shifting & sreg_q[WORD_W-1];
  end

  assign fwd_clk_tx = fwd_q;
  assign tx_busy    = (state != TX_IDLE);

  // R2: a forwarded edge only occurs while a word is being shifted.
  assert_edge_in_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_clk_tx) |-> shifting);

  // R2: lane data never moves while the forwarded clock is high.
  assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_clk_tx |-> $stable(lane_tx));

  // R3: the gap keeps clock and data low.
  assert_gap_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_GAP) |-> (!fwd_clk_tx && (lane_tx == '0)));

  // R3: a word is always followed by the gap state.
  assert_gap_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit_ev |=> (state == TX_GAP));

endmodule

// File: rtl/lane_bert_rx.sv
module lane_bert_rx
  import lane_bert_pkg::*;
#(
  parameter int LANES = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rand_mode,
  input  logic [WORD_W-1:0]        const_word,
  input  logic [LANES-1:0]        lane_rx,
  input  logic                    fwd_clk_rx,
  output logic                    word_done,
  output logic [LANES*PC_W-1:0]   bit_errs
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic             fwd_q;
  logic             armed;
  logic [BIT_W-1:0] bit_cnt;
  logic             done_q;

  // Named events.
  logic rise_ev, gap_ev, sample_ev, frame_end_ev;
  assign rise_ev      = fwd_clk_rx & ~fwd_q;
  assign gap_ev       = ~fwd_clk_rx & ~fwd_q;
  assign sample_ev    = rise_ev & armed;
  assign frame_end_ev = sample_ev & (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_q   <= 1'b0;
      armed   <= 1'b1;
      bit_cnt <= '0;
      done_q  <= 1'b0;
    end else begin
      fwd_q  <= fwd_clk_rx;
      done_q <= frame_end_ev;
      if (gap_ev) begin
        armed   <= 1'b1;
        bit_cnt <= '0;
      end else if (sample_ev) begin
        if (frame_end_ev) begin
          armed   <= 1'b0;
          bit_cnt <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    word_t sh_q;
    word_t ref_q;
    word_t exp_w;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q  <= '0;
        ref_q <= lane_seed(l);
      end else begin
        if (sample_ev) sh_q  <= {sh_q[WORD_W-2:0], lane_rx[l]};
        if (done_q)    ref_q <= lfsr_next(ref_q);
      end
    end

    assign exp_w = rand_mode ? ref_q : const_word;
    assign bit_errs[l*PC_W +: PC_W] = popcount(sh_q ^ exp_w);
  end

  assign word_done = done_q;

  // R6: arming only happens after a full bit time of low clock.
  assert_arm_after_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> (!$past(fwd_clk_rx) && !$past(fwd_q)));

  // R8: completion is a single-cycle pulse.
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);

  // R6: after a word ends, no edge is taken until the next gap.
  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_ev |=> !armed);

endmodule

// File: rtl/lane_bert_cnt.sv
module lane_bert_cnt
  import lane_bert_pkg::*;
#(
  parameter int LANES = 7,
  parameter int ERR_W = 16,
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   word_done,
  input  logic [LANES*PC_W-1:0]  bit_errs,
  output logic [LANES*ERR_W-1:0] err_cnt,
  output logic [CNT_W-1:0]       word_cnt,
  output logic                   pass
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  function automatic logic [ERR_W-1:0] sat_add(input logic [ERR_W-1:0] a,
                                               input logic [PC_W-1:0]  b);
    logic [ERR_W:0] sum;
    sum = {1'b0, a} + (ERR_W+1)'(b);
    return sum[ERR_W] ? ERR_MAX : sum[ERR_W-1:0];
  endfunction

  logic [CNT_W-1:0] word_q;
  logic [LANES-1:0] lane_clean;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  word_q <= '0;
    else if (word_done)   word_q <= word_q + 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ERR_W-1:0] err_q;

    always_ff @(posedge clk) begin
      if (!rst_n || clear) err_q <= '0;
      else if (word_done)  err_q <= sat_add(err_q, bit_errs[l*PC_W +: PC_W]);
    end

    assign err_cnt[l*ERR_W +: ERR_W] = err_q;
    assign lane_clean[l] = (err_q == '0);

    // R7: an error count never falls unless cleared.
    assert_err_no_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (err_q >= $past(err_q)));

    // R9: clear empties the counter.
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (err_q == '0));
  end

  assign word_cnt = word_q;
  assign pass     = (word_q != '0) && (&lane_clean);

  // R8: one step per completed word.
  assert_word_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !clear) |=> (word_q == $past(word_q) + CNT_W'(1)));

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_done && !clear) |=> $stable(word_q));

endmodule

// File: rtl/lane_bert.sv
module lane_bert
  import lane_bert_pkg::*;
#(
  parameter int LANES    = 7,
  parameter int ERR_W    = 16,
  parameter int CNT_W    = 32,
  parameter int GAP_BITS = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   rand_mode,
  input  logic [31:0]            const_word,
  input  logic                   clear,
  output logic [LANES-1:0]       lane_tx,
  output logic                   fwd_clk_tx,
  output logic                   tx_busy,
  input  logic [LANES-1:0]       lane_rx,
  input  logic                   fwd_clk_rx,
  output logic [LANES*ERR_W-1:0] err_cnt,
  output logic [CNT_W-1:0]       word_cnt,
  output logic                   word_done,
  output logic                   pass
);

  logic [LANES*PC_W-1:0] bit_errs;

  lane_bert_tx #(.LANES(LANES), .GAP_BITS(GAP_BITS)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rand_mode  (rand_mode),
    .const_word (const_word),
    .lane_tx    (lane_tx),
    .fwd_clk_tx (fwd_clk_tx),
    .tx_busy    (tx_busy)
  );

  lane_bert_rx #(.LANES(LANES)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rand_mode  (rand_mode),
    .const_word (const_word),
    .lane_rx    (lane_rx),
    .fwd_clk_rx (fwd_clk_rx),
    .word_done  (word_done),
    .bit_errs   (bit_errs)
  );

  lane_bert_cnt #(.LANES(LANES), .ERR_W(ERR_W), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .word_done (word_done),
    .bit_errs  (bit_errs),
    .err_cnt   (err_cnt),
    .word_cnt  (word_cnt),
    .pass      (pass)
  );

  // R1: nothing leaves the transmitter while it is idle.
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (!fwd_clk_tx && (lane_tx == '0)));

endmodule

// File: tb/lane_bert_tb_top.sv
module lane_bert_tb_top;

  localparam int NL   = 7;
  localparam int EW   = 8;
  localparam int CW   = 16;
  localparam int GB   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rand_mode = 1'b0;
  logic [31:0] const_word = '0;
  logic clear = 1'b0;
  logic [NL-1:0] lane_tx, lane_rx;
  logic fwd_clk_tx, fwd_clk_rx, tx_busy, word_done, pass;
  logic [NL*EW-1:0] err_cnt;
  logic [CW-1:0] word_cnt;

  // Loopback path with fault injection and a manual override.
  logic ov_en = 1'b0;
  logic ov_fwd = 1'b0;
  logic [NL-1:0] inv_mask = '0;
  logic [NL-1:0] stuck_mask = '0;
  assign lane_rx    = ov_en ? '0 : ((lane_tx ^ inv_mask) & ~stuck_mask);
  assign fwd_clk_rx = ov_en ? ov_fwd : fwd_clk_tx;

  always #2.5 clk = ~clk;

  lane_bert #(.LANES(NL), .ERR_W(EW), .CNT_W(CW), .GAP_BITS(GB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rand_mode(rand_mode),
    .const_word(const_word), .clear(clear), .lane_tx(lane_tx),
    .fwd_clk_tx(fwd_clk_tx), .tx_busy(tx_busy), .lane_rx(lane_rx),
    .fwd_clk_rx(fwd_clk_rx), .err_cnt(err_cnt), .word_cnt(word_cnt),
    .word_done(word_done), .pass(pass)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Transmit-side monitor on lane 0 and the forwarded clock.
  logic [31:0] mon_word = '0;
  int mon_rises = 0;
  int mon_low = 0;
  int mon_min_gap = 1000;
  int mon_unstable = 0;
  int mon_done = 0;
  logic mon_fwd_prev = 1'b0;
  logic [NL-1:0] mon_lane_prev = '0;

  always @(negedge clk) begin
    if (word_done) mon_done++;
    if (fwd_clk_tx && !mon_fwd_prev) begin
      if (mon_rises > 0 && (mon_rises % 32) == 0 && mon_low < mon_min_gap)
        mon_min_gap = mon_low;
      mon_word  <= {mon_word[30:0], lane_tx[0]};
      mon_rises++;
    end
    if (fwd_clk_tx && mon_fwd_prev && lane_tx != mon_lane_prev) mon_unstable++;
    if (fwd_clk_tx) mon_low = 0; else mon_low++;
    mon_fwd_prev  <= fwd_clk_tx;
    mon_lane_prev <= lane_tx;
  end

  // Bench model of the pattern streams and counters.
  logic [31:0] bm [NL];
  int exp_err [NL];
  int exp_words = 0;

  function automatic logic [31:0] bm_step(input logic [31:0] s);
    logic [31:0] r;
    r = {1'b0, s[31:1]};
    if (s[0]) r = r ^ 32'hB4BC_D35C;
    return r;
  endfunction

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (tx_busy && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic check_counters(input string req);
    for (int l = 0; l < NL; l++)
      chk(err_cnt[l*EW +: EW] == EW'(exp_err[l]), req, err_cnt[l*EW +: EW], exp_err[l]);
    chk(word_cnt == CW'(exp_words), req, word_cnt, exp_words);
  endtask

  // Send one word, update the model, compare counters.
  task automatic send_word(input string req, input bit rnd);
    logic [31:0] w0;
    int t;
    int done0;
    wait_idle();
    rand_mode = rnd;
    for (int l = 0; l < NL; l++) begin
      logic [31:0] sent, got;
      int e;
      sent = rnd ? bm[l] : const_word;
      if (l == 0) w0 = sent;
      got = sent;
      if (inv_mask[l])   got = ~got;
      if (stuck_mask[l]) got = '0;
      e = exp_err[l] + $countones(got ^ sent);
      exp_err[l] = (e > 255) ? 255 : e;
      bm[l] = bm_step(bm[l]);
    end
    exp_words++;
    done0 = mon_done;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (mon_done == done0 && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(mon_word == w0, {req, " lane0 serial word"}, mon_word, w0);
    check_counters(req);
  endtask

  task automatic t_reset();
    chk(err_cnt == '0, "R1 err", err_cnt, 0);
    chk(word_cnt == '0, "R1 words", word_cnt, 0);
    chk(!fwd_clk_tx && lane_tx == '0, "R1 lines", {fwd_clk_tx, lane_tx}, 0);
    chk(!tx_busy, "R1 busy", tx_busy, 0);
    chk(!pass, "R1 pass", pass, 0);
  endtask

  task automatic t_const();
    const_word = 32'hA5C3_0F96;
    send_word("R4", 1'b0);
    chk(mon_rises == 32, "R2 edges per word", mon_rises, 32);
    chk(mon_unstable == 0, "R2 data stable", mon_unstable, 0);
    chk(pass, "R10 pass after clean word", pass, 1);
    const_word = 32'h0000_0001;
    send_word("R4 second pattern", 1'b0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 3; k++) send_word("R5", 1'b1);
    chk(pass, "R10 pass random", pass, 1);
  endtask

  task automatic t_stuck();
    stuck_mask = 7'b000_1000;
    send_word("R7 stuck lane3", 1'b1);
    stuck_mask = '0;
    chk(!pass, "R10 pass low with errors", pass, 0);
  endtask

  task automatic t_saturate();
    const_word = 32'h3C3C_5A5A;
    inv_mask = 7'b000_0010;
    for (int k = 0; k < 9; k++) send_word("R7 saturate", 1'b0);
    inv_mask = '0;
    chk(err_cnt[1*EW +: EW] == 8'hFF, "R7 saturation value", err_cnt[1*EW +: EW], 8'hFF);
  endtask

  task automatic t_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    for (int l = 0; l < NL; l++) exp_err[l] = 0;
    exp_words = 0;
    check_counters("R9");
    chk(!pass, "R10 pass after clear", pass, 0);
  endtask

  task automatic t_partial();
    int d0;
    d0 = mon_done;
    wait_idle();
    @(negedge clk); ov_en = 1'b1; ov_fwd = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ov_fwd = 1'b1;
      @(negedge clk); ov_fwd = 1'b0;
    end
    wait_cycles(4);
    ov_en = 1'b0;
    wait_cycles(2);
    chk(mon_done == d0, "R6 partial burst no word", mon_done - d0, 0);
    check_counters("R6 partial burst counters");
    const_word = 32'hFFFF_0000;
    send_word("R6 recovery", 1'b0);
  endtask

  task automatic t_continuous();
    int base;
    int t;
    wait_idle();
    rand_mode = 1'b1;
    for (int k = 0; k < 3; k++) begin
      for (int l = 0; l < NL; l++) bm[l] = bm_step(bm[l]);
      exp_words++;
    end
    base = mon_rises;
    mon_min_gap = 1000;
    @(negedge clk); start = 1'b1;
    t = 0;
    while (mon_rises < base + 96 && t < 5000) begin @(negedge clk); t++; end
    start = 1'b0;
    wait_idle();
    wait_cycles(4);
    chk(mon_rises == base + 96, "R2 continuous edges", mon_rises - base, 96);
    chk(mon_min_gap >= 2*GB, "R3 gap length", mon_min_gap, 2*GB);
    check_counters("R8 continuous");
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < NL; l++) begin
      bm[l] = 32'h1234_5678 + 32'(l) * 32'h0101_0101;
      exp_err[l] = 0;
    end
    wait_cycles(4);
    rst_n = 1'b1;
    wait_cycles(2);
    t_reset();
    t_const();
    t_random();
    t_stuck();
    t_saturate();
    t_clear();
    t_partial();
    t_continuous();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule